// File: doc/BRIEF.md
# Arithmetic Status Flag Register

This block keeps the 16-bit status word of a small integer core. After each ALU operation, the ALU hands the block the two operands, the result, the operand size (byte or word) and the kind of operation. On the next clock edge the block updates the six condition flags: carry, parity, auxiliary carry, zero, sign and overflow.

Three control flags sit in the same word: single-step trap, interrupt enable and string direction. They change only through dedicated set and clear commands. Arithmetic never touches them.

The whole word can be read at all times. It can also be overwritten through a load port, which is used to restore a saved status word. Unused bit positions always read as fixed values.

Top module: `flag_unit`

## Requirements
- R1: While `rst_n` is low, and after reset, the flag word reads 16'h0002. The bit layout is: carry 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt 9, direction 10, overflow 11. Bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R2: Operation codes are `op_kind` 2'b00 for add and 2'b01 for subtract. Carry takes the carry out of the top operand bit of an add, or the borrow (unsigned minuend less than subtrahend) of a subtract. The top bit is bit 7 when `word_sz`=0 and bit 15 when `word_sz`=1.
- R3: For an add, overflow is set when both operands have the same sign and the result sign differs from it. For a subtract, overflow is set when the operand signs differ and the result sign differs from the minuend sign. A logical operation (`op_kind` 2'b10) clears overflow.
- R4: For an add or subtract, auxiliary carry is set when there is a carry (or borrow) between bit 3 and bit 4. A logical operation leaves it unchanged.
- R5: Parity is 1 when the low result byte holds an even number of ones, and 0 when that number is odd, whatever the operand size.
- R6: Zero is set exactly when every result bit within the operand size is 0.
- R7: Sign copies result bit 7 for byte operations and result bit 15 for word operations.
- R8: A logical operation clears carry.
- R9: `ctl_set[k]` sets and `ctl_clr[k]` clears control flag k (k=0 trap, k=1 interrupt, k=2 direction) on the next edge. When both are given, clear wins. Arithmetic updates never change these flags.
- R10: `load_en` writes `load_word` into the active bits and forces the fixed bits. The load takes priority over an arithmetic update and over the control commands in the same cycle.
- R11: When `upd_en` is low, or `op_kind` is 2'b11, the condition flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Apply the ALU operation presented this cycle |
| op_kind | input | 2 | 00 add, 01 subtract, 10 logical, 11 no update |
| word_sz | input | 1 | 1 for 16-bit operation, 0 for 8-bit |
| opa | input | 16 | First operand (minuend for subtract) |
| opb | input | 16 | Second operand (subtrahend for subtract) |
| res | input | 16 | ALU result |
| ctl_set | input | 3 | Set commands for trap, interrupt, direction |
| ctl_clr | input | 3 | Clear commands for trap, interrupt, direction |
| load_en | input | 1 | Restore the flag word from `load_word` |
| load_word | input | 16 | Flag word to restore |
| flags | output | 16 | Current flag word |

## Verification
The assertions take for granted that `res` is really the sum, difference or logical combination of `opa` and `opb` for the size given. Auxiliary carry and overflow are taken from the result bits, so an inconsistent result would make those checks meaningless. The stimulus therefore always computes `res` from the operands it drives. Only the upper byte is left free for byte operations, and the size rules say it must not matter there.

// File: rtl/flag_unit.sv
module flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_en,
  input  logic [1:0]  op_kind,
  input  logic        word_sz,
  input  logic [15:0] opa,
  input  logic [15:0] opb,
  input  logic [15:0] res,
  input  logic [2:0]  ctl_set,
  input  logic [2:0]  ctl_clr,
  input  logic        load_en,
  input  logic [15:0] load_word,
  output logic [15:0] flags
);
  localparam int CF = 0, PF = 2, AF = 4, ZF = 6, SF = 7, TF = 8, OF = 11;
  localparam logic [15:0] ACTIVE = 16'h0FD5;
  localparam logic [15:0] FIXED  = 16'h0002;
  localparam logic [1:0]  OP_ADD = 2'b00, OP_SUB = 2'b01, OP_LOG = 2'b10;

  logic [16:0] sum_w;
  logic [8:0]  sum_b;
  logic        a_s, b_s, r_s;
  logic        c_add, c_sub, v_add, v_sub;
  logic        aux, zer, par;

  assign sum_w = {1'b0, opa} + {1'b0, opb};
  assign sum_b = {1'b0, opa[7:0]} + {1'b0, opb[7:0]};

  assign a_s = word_sz ? opa[15] : opa[7];
  assign b_s = word_sz ? opb[15] : opb[7];
  assign r_s = word_sz ? res[15] : res[7];

  assign c_add = word_sz ? sum_w[16] : sum_b[8];
  assign c_sub = word_sz ? (opa < opb) : (opa[7:0] < opb[7:0]);
  assign v_add = (a_s == b_s) && (r_s != a_s);
  assign v_sub = (a_s != b_s) && (r_s != a_s);

  assign aux = opa[4] ^ opb[4] ^ res[4];
  assign zer = word_sz ? (res == 16'h0000) : (res[7:0] == 8'h00);
  assign par = ~^res[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= FIXED;
    end else if (load_en) begin
      flags <= (load_word & ACTIVE) | FIXED;
    end else begin
      if (upd_en && op_kind != 2'b11) begin
        flags[PF] <= par;
        flags[ZF] <= zer;
        flags[SF] <= r_s;
        case (op_kind)
          OP_ADD: begin
            flags[CF] <= c_add;
            flags[AF] <= aux;
            flags[OF] <= v_add;
          end
          OP_SUB: begin
            flags[CF] <= c_sub;
            flags[AF] <= aux;
            flags[OF] <= v_sub;
          end
          OP_LOG: begin
            flags[CF] <= 1'b0;
            flags[OF] <= 1'b0;
          end
          default: ;
        endcase
      end
      for (int k = 0; k < 3; k++)
        flags[TF+k] <= (flags[TF+k] | ctl_set[k]) & ~ctl_clr[k];
    end
  end
endmodule

module flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_en,
  input logic [1:0]  op_kind,
  input logic        word_sz,
  input logic [15:0] opa,
  input logic [15:0] opb,
  input logic [15:0] res,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic        load_en,
  input logic [15:0] load_word,
  input logic [15:0] flags
);
  logic arith;
  assign arith = upd_en && !load_en && (op_kind != 2'b11);

  p_fixed_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'hF02A) == 16'h0002);

  p_logic_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arith && op_kind == 2'b10 |=> !flags[0]);

  p_logic_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arith && op_kind == 2'b10 |=> !flags[11]);

  p_logic_keeps_aux_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arith && op_kind == 2'b10 |=> flags[4] == $past(flags[4]));

  p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arith |=> flags[2] == ~^$past(res[7:0]));

  p_zero_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arith && word_sz && res == 16'h0 |=> flags[6]);

  p_ctl_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && ctl_set == 3'b0 && ctl_clr == 3'b0 |=> $stable(flags[10:8]));

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> flags == (($past(load_word) & 16'h0FD5) | 16'h0002));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !arith |=> flags[11] == $past(flags[11]) && flags[7:0] == $past(flags[7:0]));
endmodule

bind flag_unit flag_unit_chk chk (.*);

// File: tb/flag_unit_test.sv
module flag_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        upd_en = 0;
  logic [1:0]  op_kind = 0;
  logic        word_sz = 0;
  logic [15:0] opa = 0, opb = 0, res = 0;
  logic [2:0]  ctl_set = 0, ctl_clr = 0;
  logic        load_en = 0;
  logic [15:0] load_word = 0;
  logic [15:0] flags;
  logic [15:0] exp_f = 16'h0002;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  flag_unit uut (.*);

  function automatic logic [15:0] model(input logic [15:0] cur);
    logic [15:0] f;
    int n, lim, half, ai, bi, ri, sa, sb, sr, ones;
    f = cur;
    if (load_en) return (load_word & 16'h0FD5) | 16'h0002;
    if (upd_en && op_kind != 2'b11) begin
      n = word_sz ? 16 : 8;
      lim = 1 << n;
      half = lim / 2;
      ai = int'(opa) % lim;
      bi = int'(opb) % lim;
      ri = int'(res) % lim;
      sa = (ai >= half) ? ai - lim : ai;
      sb = (bi >= half) ? bi - lim : bi;
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(res[i]);
      f[2] = (ones % 2) == 0;
      f[6] = (ri == 0);
      f[7] = (ri >= half);
      if (op_kind == 2'b00) begin
        sr = sa + sb;
        f[0] = (ai + bi) >= lim;
        f[4] = (ai % 16 + bi % 16) > 15;
        f[11] = (sr > half - 1) || (sr < -half);
      end else if (op_kind == 2'b01) begin
        sr = sa - sb;
        f[0] = ai < bi;
        f[4] = (ai % 16) < (bi % 16);
        f[11] = (sr > half - 1) || (sr < -half);
      end else begin
        f[0] = 0;
        f[11] = 0;
      end
    end
    for (int k = 0; k < 3; k++) begin
      if (ctl_clr[k]) f[8+k] = 0;
      else if (ctl_set[k]) f[8+k] = 1;
    end
    return f;
  endfunction

  task automatic check(input string tag);
    tests++;
    if (flags !== exp_f) begin
      fails++;
      $display("FAIL %s flags got %h expected %h", tag, flags, exp_f);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    exp_f = model(exp_f);
    #1;
    check(tag);
    @(negedge clk);
    upd_en = 0; load_en = 0; ctl_set = 0; ctl_clr = 0;
  endtask

  task automatic alu(input logic [1:0] op, input logic ws, input logic [15:0] a, input logic [15:0] b,
                     input string tag);
    upd_en = 1; op_kind = op; word_sz = ws; opa = a; opb = b;
    case (op)
      2'b00: res = a + b;
      2'b01: res = a - b;
      default: res = a ^ b;
    endcase
    step(tag);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset value");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");

    alu(2'b00, 0, 16'h00FF, 16'h0001, "R2 R4 R6 byte add carry to zero");
    alu(2'b00, 1, 16'h7FFF, 16'h0001, "R3 R7 word add overflow sign");
    alu(2'b00, 0, 16'h1270, 16'h3410, "R3 byte add overflow");
    alu(2'b01, 0, 16'h0000, 16'h0001, "R2 byte borrow");
    alu(2'b01, 1, 16'h8000, 16'h0001, "R3 word sub overflow");
    alu(2'b01, 1, 16'h1234, 16'h1234, "R6 word sub zero");
    alu(2'b00, 1, 16'h0100, 16'h0000, "R6 R5 word nonzero with zero low byte");
    alu(2'b00, 0, 16'h0008, 16'h0008, "R4 aux carry byte");
    alu(2'b10, 1, 16'hFFFF, 16'h0001, "R8 R4 logical keeps aux");
    alu(2'b00, 0, 16'h0003, 16'h0004, "R5 odd parity");

    upd_en = 0; op_kind = 2'b00; opa = 16'hFFFF; opb = 16'h0001; res = 16'h0000;
    step("R11 upd_en low holds");
    upd_en = 1; op_kind = 2'b11;
    step("R11 reserved op holds");

    ctl_set = 3'b111;
    step("R9 set control flags");
    alu(2'b01, 1, 16'h0000, 16'h0001, "R9 arithmetic leaves control");
    ctl_set = 3'b011; ctl_clr = 3'b010;
    step("R9 clear wins");
    ctl_clr = 3'b101;
    step("R9 clear");

    load_word = 16'hFFFF; load_en = 1; upd_en = 1; op_kind = 2'b10; ctl_clr = 3'b111;
    step("R10 load priority");
    load_word = 16'h0000; load_en = 1;
    step("R10 load zeros");

    for (int i = 0; i < 3000; i++) begin
      ctl_set = 3'($urandom);
      ctl_clr = 3'($urandom) & 3'($urandom);
      load_en = ($urandom % 16) == 0;
      load_word = 16'($urandom);
      alu(2'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), "R2 R3 R4 R5 R6 R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule